// File: doc/BRIEF.md
# Freezable Performance Counter Box

This block holds three event counters that software programs and reads through a plain 32-bit register port addressed with byte offsets in a configuration-space layout. Each counter has its own control word that enables it and picks one of the event inputs. While the box is running, an enabled counter adds one on every clock in which its selected event is high.

When any counter wraps past its all-ones value, the box records the wrap in a sticky status bit for that counter and freezes every counter at once. Software then reads a coherent snapshot and clears the status bits by writing ones to them. Counting restarts only after the global enable input rises again while no status bit is set. A box-wide control word also provides a manual freeze, a one-shot clear of all counter values and a one-shot clear of all counter control words.

Top module: `perf_box`

## Requirements
- R1: After synchronous reset every mapped register reads 0 and no counter counts until software enables it.
- R2: Offsets: status 0xF8, box control 0xF4, counter control i at 0xD8+4*i, counter i low word at 0xA0+8*i and high word at 0xA4+8*i; any other offset reads 0 and a write there changes nothing.
- R3: Counter i adds one on each clock edge at which bit 22 of its control word is set, bits [7:0] of that word select an event input that is high, the box is not frozen and the global enable is high; a selection of 8 or more never counts.
- R4: Counters are 48 bits: the low word holds bits [31:0], bits [15:0] of the high word hold bits [47:32] and its upper 16 bits read 0; a write to either word loads it directly and wins over an increment at the same edge.
- R5: An increment from all ones wraps the counter to 0, sets status bit i at that same edge and freezes the whole box.
- R6: Writing 1 to a status bit clears it; writing 0 leaves it unchanged.
- R7: An overflow freeze holds until a rising edge of the global enable is seen while all status bits are already 0; a rise while any status bit is set, or clearing the status with the enable held high, does not release it.
- R8: Bit 8 of box control is a read/write manual freeze that halts all counters while set.
- R9: Writing 1 to bit 1 of box control clears all counter values and writing 1 to bit 0 clears all counter control words; both bits read back as 0.
- R10: While the global enable input is low no counter changes except by a software write or clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Global counting enable; its rising edge releases an overflow freeze |
| evt_i | input | 8 | Event inputs, one per selectable event |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
A wrong freeze state shows as a counter value that moves, or fails to move, by the number of clocks the events were held high, visible at the next read of the low word. A wrong status bit shows at once on a read of offset 0xF8 and, one release attempt later, as a box that stays frozen or resumes when it should not. Selection and enable faults show as a count of 0 where the sweep expects the run length, or the reverse, on the very next read.

// File: rtl/perf_box_pkg.sv
// Shared constants and address helpers for the performance counter box.
// Assumes 8-bit byte offsets and 32-bit register words.
package perf_box_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam logic [ADDR_W-1:0] A_STATUS = 8'hF8;
    localparam logic [ADDR_W-1:0] A_BOXCTL = 8'hF4;
    localparam logic [ADDR_W-1:0] A_CTL0   = 8'hD8;
    localparam logic [ADDR_W-1:0] A_CTR0   = 8'hA0;
    localparam int BC_FRZ    = 8;
    localparam int BC_RSTCTR = 1;
    localparam int BC_RSTCTL = 0;

    // Offset of the control word of counter idx
    function automatic logic [ADDR_W-1:0] ctl_addr(input int idx);
        return ADDR_W'(int'(A_CTL0) + 4 * idx);
    endfunction

    // Offset of the low data word of counter idx
    function automatic logic [ADDR_W-1:0] lo_addr(input int idx);
        return ADDR_W'(int'(A_CTR0) + 8 * idx);
    endfunction

    // Offset of the high data word of counter idx
    function automatic logic [ADDR_W-1:0] hi_addr(input int idx);
        return ADDR_W'(int'(A_CTR0) + 8 * idx + 4);
    endfunction
endpackage

// File: rtl/perf_ctr_slice.sv
// One counter with its control word. Counts its selected event when enabled
// and when cnt_ok is high; flags a wrap from all ones. Assumes 32 < CTR_W <= 64.
// Priority on the value: clear, then software load, then increment.
module perf_ctr_slice
    import perf_box_pkg::*;
#(
    parameter int CTR_W   = 48,
    parameter int NUM_EVT = 8,
    parameter int SEL_W   = 8,
    parameter int EN_BIT  = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              ctl_clr,
    input  logic              cnt_clr,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic              cnt_ok,
    output logic [DATA_W-1:0] ctl_q,
    output logic [CTR_W-1:0]  cnt_q,
    output logic              ovf_o
);
    localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
    localparam int HI_W  = CTR_W - DATA_W;

    logic [SEL_W-1:0] sel;
    logic             sel_ok;
    logic             evt_hit;
    logic             inc;
    logic             load;

    assign sel     = ctl_q[SEL_W-1:0];
    assign sel_ok  = ({1'b0, sel} < (SEL_W + 1)'(NUM_EVT));
    assign evt_hit = sel_ok && evt_i[sel[IDX_W-1:0]];
    assign inc     = ctl_q[EN_BIT] && evt_hit && cnt_ok;
    assign load    = lo_we || hi_we;
    assign ovf_o   = inc && !cnt_clr && !load && (&cnt_q);

    // Control word: cleared by reset or box-wide clear, else written by software
    always_ff @(posedge clk) begin
        if (!rst_n || ctl_clr) begin
            ctl_q <= '0;
        end else if (ctl_we) begin
            ctl_q <= wdata;
        end
    end

    // Counter value: clear, software load, or increment
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr) begin
            cnt_q <= '0;
        end else if (lo_we) begin
            cnt_q[DATA_W-1:0] <= wdata;
        end else if (hi_we) begin
            cnt_q[CTR_W-1:DATA_W] <= wdata[HI_W-1:0];
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/perf_box_ctl.sv
// Box-wide state: sticky overflow status (write-1-to-clear), manual freeze,
// overflow freeze and the one-shot clear pulses. An overflow freeze is released
// only by a global-enable rise seen while the status is already all zero.
module perf_box_ctl
    import perf_box_pkg::*;
#(
    parameter int NUM_CTR = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               st_we,
    input  logic               bc_we,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_CTR-1:0] ovf_vec,
    input  logic               glb_en,
    output logic [NUM_CTR-1:0] status_q,
    output logic               frz_q,
    output logic               ovf_frz_q,
    output logic               clr_cnt,
    output logic               clr_ctl,
    output logic               cnt_ok
);
    logic               glb_q;
    logic               glb_rise;
    logic [NUM_CTR-1:0] clr_mask;

    assign glb_rise = glb_en && !glb_q;
    assign clr_mask = st_we ? wdata[NUM_CTR-1:0] : '0;
    assign clr_cnt  = bc_we && wdata[BC_RSTCTR];
    assign clr_ctl  = bc_we && wdata[BC_RSTCTL];
    assign cnt_ok   = glb_en && !frz_q && !ovf_frz_q;

    // Previous global enable, for rise detection
    always_ff @(posedge clk) begin
        if (!rst_n) glb_q <= 1'b0;
        else        glb_q <= glb_en;
    end

    // Sticky status: new overflows set, ones written clear; set wins
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | ovf_vec;
    end

    // Manual freeze bit, plain read/write
    always_ff @(posedge clk) begin
        if (!rst_n)     frz_q <= 1'b0;
        else if (bc_we) frz_q <= wdata[BC_FRZ];
    end

    // Overflow freeze: set by any wrap, released by enable rise with clear status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_frz_q <= 1'b0;
        end else if (|ovf_vec) begin
            ovf_frz_q <= 1'b1;
        end else if (glb_rise && (status_q == '0)) begin
            ovf_frz_q <= 1'b0;
        end
    end
endmodule

// File: rtl/perf_box.sv
// Top of the performance counter box: register decode, read mux, one slice
// per counter and the box-wide control. Reads are combinational on reg_addr.
module perf_box
    import perf_box_pkg::*;
#(
    parameter int NUM_CTR = 3,
    parameter int CTR_W   = 48,
    parameter int NUM_EVT = 8,
    parameter int SEL_W   = 8,
    parameter int EN_BIT  = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glb_en,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata
);
    localparam int HI_W = CTR_W - DATA_W;

    logic [DATA_W-1:0]        ctl_q [NUM_CTR];
    logic [CTR_W-1:0]         cnt_q [NUM_CTR];
    logic [NUM_CTR*CTR_W-1:0] cnt_flat;
    logic [NUM_CTR-1:0]       ovf_vec;
    logic [NUM_CTR-1:0]       status_q;
    logic                     frz_q;
    logic                     ovf_frz_q;
    logic                     clr_cnt;
    logic                     clr_ctl;
    logic                     cnt_ok;
    logic                     st_we;
    logic                     bc_we;

    assign st_we = reg_we && (reg_addr == A_STATUS);
    assign bc_we = reg_we && (reg_addr == A_BOXCTL);

    perf_box_ctl #(.NUM_CTR(NUM_CTR)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_we     (st_we),
        .bc_we     (bc_we),
        .wdata     (reg_wdata),
        .ovf_vec   (ovf_vec),
        .glb_en    (glb_en),
        .status_q  (status_q),
        .frz_q     (frz_q),
        .ovf_frz_q (ovf_frz_q),
        .clr_cnt   (clr_cnt),
        .clr_ctl   (clr_ctl),
        .cnt_ok    (cnt_ok)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        logic ctl_we_i;
        logic lo_we_i;
        logic hi_we_i;

        assign ctl_we_i = reg_we && (reg_addr == ctl_addr(i));
        assign lo_we_i  = reg_we && (reg_addr == lo_addr(i));
        assign hi_we_i  = reg_we && (reg_addr == hi_addr(i));
        assign cnt_flat[i*CTR_W +: CTR_W] = cnt_q[i];

        perf_ctr_slice #(
            .CTR_W   (CTR_W),
            .NUM_EVT (NUM_EVT),
            .SEL_W   (SEL_W),
            .EN_BIT  (EN_BIT)
        ) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_we  (ctl_we_i),
            .ctl_clr (clr_ctl),
            .cnt_clr (clr_cnt),
            .lo_we   (lo_we_i),
            .hi_we   (hi_we_i),
            .wdata   (reg_wdata),
            .evt_i   (evt_i),
            .cnt_ok  (cnt_ok),
            .ctl_q   (ctl_q[i]),
            .cnt_q   (cnt_q[i]),
            .ovf_o   (ovf_vec[i])
        );
    end

    // Read mux: mapped offsets return their word, everything else reads 0
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_STATUS) begin
            reg_rdata[NUM_CTR-1:0] = status_q;
        end else if (reg_addr == A_BOXCTL) begin
            reg_rdata[BC_FRZ] = frz_q;
        end
        for (int i = 0; i < NUM_CTR; i++) begin
            if (reg_addr == ctl_addr(i)) reg_rdata = ctl_q[i];
            if (reg_addr == lo_addr(i))  reg_rdata = cnt_q[i][DATA_W-1:0];
            if (reg_addr == hi_addr(i))  reg_rdata = {{(DATA_W-HI_W){1'b0}}, cnt_q[i][CTR_W-1:DATA_W]};
        end
    end
endmodule

// File: rtl/perf_box_chk.sv
// Checker for perf_box: relates port activity to the status, freeze and
// counter state over time. Attached to every perf_box by the bind below.
module perf_box_chk
    import perf_box_pkg::*;
#(
    parameter int NUM_CTR = 3,
    parameter int CTR_W   = 48
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     glb_en,
    input logic                     reg_we,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic [DATA_W-1:0]        reg_wdata,
    input logic [DATA_W-1:0]        reg_rdata,
    input logic [NUM_CTR-1:0]       status_q,
    input logic                     frz_q,
    input logic                     ovf_frz_q,
    input logic [NUM_CTR-1:0]       ovf_vec,
    input logic [NUM_CTR*CTR_W-1:0] cnt_flat
);
    logic [NUM_CTR-1:0] w1c_mask;
    assign w1c_mask = (reg_we && reg_addr == A_STATUS) ? reg_wdata[NUM_CTR-1:0] : '0;

    AST_OVF_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ovf_vec) |=> ovf_frz_q && ((status_q & $past(ovf_vec)) == $past(ovf_vec))); // R5

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status_q) & ~$past(w1c_mask)) & ~status_q) == '0)); // R6

    AST_FREEZE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_frz_q && status_q != '0) |=> ovf_frz_q); // R7

    AST_OVF_FROZEN_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_frz_q && !reg_we) |=> $stable(cnt_flat)); // R7

    AST_MANUAL_FROZEN_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_q && !reg_we) |=> $stable(cnt_flat)); // R8

    AST_PULSE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_BOXCTL) |-> (reg_rdata[BC_RSTCTR] == 1'b0 && reg_rdata[BC_RSTCTL] == 1'b0)); // R9

    AST_GLOBAL_OFF_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && !reg_we) |=> $stable(cnt_flat)); // R10
endmodule

bind perf_box perf_box_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glb_en    (glb_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .status_q  (status_q),
    .frz_q     (frz_q),
    .ovf_frz_q (ovf_frz_q),
    .ovf_vec   (ovf_vec),
    .cnt_flat  (cnt_flat)
);

// File: tb/tb_perf_box.sv
// Self-checking bench: sweeps counter, selection and event pattern, then
// walks the freeze, overflow and clear sequences with arithmetic expectations.
`timescale 1ns/1ps
module tb_perf_box;
    import perf_box_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glb_en = 1'b0;
    logic [7:0]  evt_i = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    localparam logic [31:0] EN = 32'h1 << 22;

    perf_box dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .glb_en    (glb_en),
        .evt_i     (evt_i),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always #2.5 clk = ~clk;

    // Compare one value and report
    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // One register write, applied at exactly one rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // Combinational read, sampled mid-cycle
    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Hold an event pattern for n rising edges
    task automatic run_evt(input logic [7:0] m, input int n);
        @(negedge clk);
        evt_i = m;
        repeat (n) @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        logic [31:0] d;
        logic [7:0]  pats [4];
        pats[0] = 8'hFF; pats[1] = 8'h00; pats[2] = 8'h55; pats[3] = 8'hA6;
        repeat (3) @(negedge clk);

        // R1: everything reads 0 in reset
        rd(A_STATUS, d); chk("R1 status", d, 0);
        rd(A_BOXCTL, d); chk("R1 boxctl", d, 0);
        for (int i = 0; i < 3; i++) begin
            rd(ctl_addr(i), d); chk("R1 ctl", d, 0);
            rd(lo_addr(i), d);  chk("R1 lo", d, 0);
            rd(hi_addr(i), d);  chk("R1 hi", d, 0);
        end
        @(negedge clk); rst_n = 1'b1; glb_en = 1'b1;

        // R2: decode and unmapped offsets
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R2 unmapped 00", d, 0);
        rd(8'hFC, d); chk("R2 unmapped FC", d, 0);
        wr(8'hDC, 32'h0001_2345);
        rd(8'hDC, d); chk("R2 ctl1", d, 32'h0001_2345);
        rd(8'hD8, d); chk("R2 ctl0 untouched", d, 0);
        rd(8'hE0, d); chk("R2 ctl2 untouched", d, 0);

        // R3: sweep counter x selection x pattern
        for (int c = 0; c < 3; c++) begin
            for (int s = 0; s < 10; s++) begin
                for (int p = 0; p < 4; p++) begin
                    int exp;
                    wr(A_BOXCTL, 32'h3);
                    wr(ctl_addr(c), EN | 32'(s));
                    run_evt(pats[p], 5);
                    exp = (s < 8 && pats[p][s % 8]) ? 5 : 0;
                    rd(lo_addr(c), d); chk("R3 sweep count", d, 32'(exp));
                end
            end
        end
        wr(A_BOXCTL, 32'h3);
        wr(ctl_addr(0), 32'h0);
        run_evt(8'hFF, 4);
        rd(lo_addr(0), d); chk("R3 no enable bit", d, 0);

        // R10: global enable low halts counting
        wr(ctl_addr(0), EN);
        @(negedge clk); glb_en = 1'b0;
        run_evt(8'h01, 4);
        rd(lo_addr(0), d); chk("R10 glb low", d, 0);
        @(negedge clk); glb_en = 1'b1;
        run_evt(8'h01, 2);
        rd(lo_addr(0), d); chk("R10 glb high", d, 2);

        // R8: manual freeze
        wr(A_BOXCTL, 32'h100);
        rd(A_BOXCTL, d); chk("R8 freeze readback", d, 32'h100);
        run_evt(8'h01, 4);
        rd(lo_addr(0), d); chk("R8 frozen", d, 2);
        wr(A_BOXCTL, 32'h0);
        run_evt(8'h01, 3);
        rd(lo_addr(0), d); chk("R8 unfrozen", d, 5);

        // R9: one-shot clears
        wr(A_BOXCTL, 32'h102);
        rd(A_BOXCTL, d); chk("R9 pulse bits read 0", d, 32'h100);
        rd(lo_addr(0), d); chk("R9 counters cleared", d, 0);
        rd(ctl_addr(0), d); chk("R9 ctl kept", d, EN);
        wr(A_BOXCTL, 32'h1);
        rd(ctl_addr(0), d); chk("R9 ctl cleared", d, 0);
        rd(A_BOXCTL, d); chk("R9 freeze off", d, 0);

        // R4: high word, load priority, carry
        wr(hi_addr(2), 32'hFFFF_FFFF);
        rd(hi_addr(2), d); chk("R4 hi upper zero", d, 32'h0000_FFFF);
        wr(ctl_addr(1), EN | 32'd2);
        @(negedge clk);
        evt_i = 8'h04; reg_we = 1'b1; reg_addr = lo_addr(1); reg_wdata = 32'd100;
        @(negedge clk);
        reg_we = 1'b0; evt_i = '0;
        rd(lo_addr(1), d); chk("R4 load wins", d, 100);
        run_evt(8'h04, 3);
        rd(lo_addr(1), d); chk("R4 count after load", d, 103);
        wr(lo_addr(1), 32'hFFFF_FFFF);
        run_evt(8'h04, 1);
        rd(lo_addr(1), d); chk("R4 carry lo", d, 0);
        rd(hi_addr(1), d); chk("R4 carry hi", d, 1);

        // R5 R6 R7: overflow freeze and release
        wr(A_BOXCTL, 32'h3);
        wr(ctl_addr(0), EN | 32'd0);
        wr(ctl_addr(1), EN | 32'd1);
        wr(lo_addr(0), 32'hFFFF_FFFE);
        wr(hi_addr(0), 32'h0000_FFFF);
        run_evt(8'h03, 5);
        rd(lo_addr(0), d); chk("R5 wrap lo", d, 0);
        rd(hi_addr(0), d); chk("R5 wrap hi", d, 0);
        rd(lo_addr(1), d); chk("R5 box frozen", d, 2);
        rd(A_STATUS, d);   chk("R5 status bit0", d, 32'h1);
        wr(A_STATUS, 32'h0);
        rd(A_STATUS, d);   chk("R6 write 0 keeps", d, 32'h1);
        wr(A_STATUS, 32'h6);
        rd(A_STATUS, d);   chk("R6 other bits keep", d, 32'h1);
        @(negedge clk); glb_en = 1'b0;
        @(negedge clk); glb_en = 1'b1;
        run_evt(8'h03, 3);
        rd(lo_addr(1), d); chk("R7 rise with status set", d, 2);
        wr(A_STATUS, 32'h1);
        rd(A_STATUS, d);   chk("R6 write 1 clears", d, 0);
        run_evt(8'h03, 3);
        rd(lo_addr(1), d); chk("R7 held without rise", d, 2);
        @(negedge clk); glb_en = 1'b0;
        @(negedge clk); glb_en = 1'b1;
        run_evt(8'h03, 3);
        rd(lo_addr(1), d); chk("R7 released c1", d, 5);
        rd(lo_addr(0), d); chk("R7 released c0", d, 3);

        // R5: overflow of counter 2 sets only bit 2
        wr(ctl_addr(2), EN | 32'd7);
        wr(lo_addr(2), 32'hFFFF_FFFF);
        wr(hi_addr(2), 32'h0000_FFFF);
        run_evt(8'h80, 1);
        rd(A_STATUS, d);   chk("R5 status bit2", d, 32'h4);
        run_evt(8'h83, 2);
        rd(lo_addr(1), d); chk("R5 c1 frozen", d, 5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog got=timeout exp=done");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule